// File: doc/BRIEF.md
# Block-Framed Serial Data Line Sequencer

This block drives and samples the single data line of a memory-card style link from the host side. One control word selects the transfer. Stream format carries an open-ended run of bytes. Block format carries fixed-length blocks of 2^N bytes, either as one block or as a chain of blocks. On transmit, bytes come in over a valid/ready interface. They are sent MSB first inside a frame made of a low start bit, the data, a CRC16 and a high end bit. On receive, the block waits for the start bit, assembles bytes and hands them out over a valid/ready interface. At the end of each frame it reports a CRC status and a framing status.

The host owns the bit clock. `bit_slot_o` marks every cycle in which one bit crosses the line, and the attached card model shifts one bit per marked cycle. Back-pressure works by withholding bit slots. On transmit, ready is offered only at a byte boundary, and the line pauses there until valid arrives. On receive, a byte that cannot be stored because the previous byte is still unaccepted holds back the slot of its last bit. Received data is therefore never dropped. `rx_valid_o` and `rx_data_o` stay stable until `rx_ready_i` is seen.

Top module: `dline_seq`

## Requirements
- R1: Configuration is sampled when a transfer starts from idle. `cfg_blk_i`=0 selects stream format and 1 selects block format. In block format `cfg_len_i`=N (0..11) sets a block of 2^N bytes, i.e. 8*2^N data bits per frame.
- R2: Starting in block format with `cfg_len_i` above 11 moves no bit and keeps `busy_o` low. `len_err_o` rises the cycle after the start and stays high until `cfg_en_i` is cleared.
- R3: A transmitted block frame on `line_o` is a 0 start bit, the data bytes MSB first, 16 CRC bits MSB first, and a 1 end bit. The line reads 1 whenever no transmit bit is in its slot.
- R4: The CRC16 uses polynomial x^16+x^12+x^5+1 (0x1021), starts at 0 with no final inversion, and covers the data bits only.
- R5: Transmit bytes are accepted on `tx_valid_i`&&`tx_ready_o`. `tx_ready_o` is high only at a byte boundary. When no byte is offered there, no bit slot is issued.
- R6: Receive waits for a 0 bit and then assembles bytes MSB first. Each byte is presented on `rx_data_o` with `rx_valid_o`, which holds with stable data until `rx_ready_i`. The last bit of the following byte is not clocked in while a byte is still pending.
- R7: At the end of each received frame, `fmt_err_o` is set if the end bit was 0, and `crc_err_o` is set if the block's CRC did not match (always 0 in stream format). Both change only together with `eof_o` or when a new transfer starts from idle, which clears them.
- R8: In single-block mode, after one block the line falls silent and `busy_o` drops. The block waits for `cfg_en_i` to be cleared before it can start again.
- R9: In multi-block mode, blocks follow back to back while `cfg_en_i` is high at the end of a block, with one `eof_o` per block. Clearing `cfg_en_i` mid-block lets that block finish.
- R10: In stream format the frame is a 0 start bit, whole bytes, and a 1 end bit, with no CRC. The length code is ignored. The stream ends at the first byte boundary where `cfg_en_i` is low.
- R11: `busy_o` is low after reset and high throughout every frame, so every bit slot occurs while busy.
- R12: `eof_o` is a single-cycle pulse in the cycle after each end-bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Transfer enable |
| cfg_tx_i | input | 1 | 1 = transmit, 0 = receive |
| cfg_blk_i | input | 1 | 0 = stream format, 1 = block format |
| cfg_multi_i | input | 1 | 1 = repeated blocks, 0 = single block |
| cfg_len_i | input | 4 | Block length code N, block = 2^N bytes |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmit byte accepted when valid is high |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte valid |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| line_o | output | 1 | Serial data driven to the card |
| line_i | input | 1 | Serial data from the card |
| bit_slot_o | output | 1 | One line bit crosses on this cycle's edge |
| busy_o | output | 1 | Frame in progress |
| eof_o | output | 1 | End-of-frame pulse |
| len_err_o | output | 1 | Reserved length code refused |
| crc_err_o | output | 1 | Last received block failed its CRC |
| fmt_err_o | output | 1 | Last received frame had a 0 end bit |

## Verification
The bench sweeps block lengths from one byte to 32 bytes, plus the 2048-byte maximum, with random stalls on both handshakes. A wrong length decode or an off-by-one in the bit counter shows up as a short or long frame, and a CRC shifted out in the wrong order shows up as bit mismatches. On receive it injects a corrupted CRC and a zero end bit, then runs a clean frame right after. A design that swapped the two flags, or failed to clear them on restart, reports stale errors. Multi-block runs with the enable dropped mid-block show whether a design cuts the block short or chains too many. Stream runs with an illegal length code and the reserved-code refusals catch a design that applies the length check in the wrong format.

// File: rtl/dline_pkg.sv
package dline_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HOLD,
    S_TSTART,
    S_TDATA,
    S_TCRC,
    S_TEND,
    S_RWAIT,
    S_RDATA,
    S_RCRC,
    S_REND
  } dl_state_t;

  // One serial step of a left-shifting CRC register.
  function automatic logic [15:0] crc_step(input logic [15:0] c,
                                           input logic b,
                                           input logic [15:0] poly);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
  endfunction

endpackage

// File: rtl/dline_cfg.sv
module dline_cfg #(
  parameter int MAX_CODE = 11,
  parameter int CODE_W   = 4,
  parameter int CNT_W    = MAX_CODE + 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              legal_o,
  output logic [CNT_W-1:0]  last_o
);

  assign legal_o = (code_i <= CODE_W'(MAX_CODE));

  // Index of the final data bit of a block: 8 * 2^N - 1.
  always_comb begin
    last_o = '0;
    for (int i = 0; i <= MAX_CODE; i++) begin
      if (code_i == CODE_W'(i)) last_o = CNT_W'((1 << (i + 3)) - 1);
    end
  end

endmodule

// File: rtl/dline_cnt.sv
module dline_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_o <= '0;
    else if (clr) cnt_o <= '0;
    else if (inc) cnt_o <= cnt_o + W'(1);
  end

endmodule

// File: rtl/dline_crc16.sv
module dline_crc16 #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        din,
  output logic [15:0] crc_o
);
  import dline_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_o <= '0;
    else if (clr) crc_o <= '0;
    else if (en)  crc_o <= crc_step(crc_o, din, POLY);
  end

endmodule

// File: rtl/dline_seq.sv
module dline_seq #(
  parameter int          MAX_CODE = 11,
  parameter int          CODE_W   = 4,
  parameter logic [15:0] POLY     = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en_i,
  input  logic              cfg_tx_i,
  input  logic              cfg_blk_i,
  input  logic              cfg_multi_i,
  input  logic [CODE_W-1:0] cfg_len_i,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              line_o,
  input  logic              line_i,
  output logic              bit_slot_o,
  output logic              busy_o,
  output logic              eof_o,
  output logic              len_err_o,
  output logic              crc_err_o,
  output logic              fmt_err_o
);
  import dline_pkg::*;

  localparam int CNT_W = MAX_CODE + 3;
  localparam int CRC_CW = 4;

  dl_state_t st, st_n;

  logic              c_tx, c_blk, c_multi;
  logic [CODE_W-1:0] c_code;
  logic [CODE_W-1:0] code_sel;
  logic              code_legal;
  logic [CNT_W-1:0]  last_bit;
  logic [CNT_W-1:0]  dcnt;
  logic [CRC_CW-1:0] ccnt;
  logic [2:0]        bidx;
  logic [15:0]       crc;
  logic [7:0]        sh;
  logic [7:0]        rx_data_q;
  logic              rx_valid_q, eof_q, lerr_q, crc_err_q, fmt_err_q;

  logic d_clr, d_inc, c_clr, c_inc, crc_clr, crc_en, crc_din;
  logic start, lerr_set, blk_end, tx_adv, rx_adv, rx_stall, stream_stop;

  // The live length code is checked at start; the latched one sizes the block.
  assign code_sel = (st == S_IDLE) ? cfg_len_i : c_code;

  dline_cfg #(.MAX_CODE(MAX_CODE), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_cfg (
    .code_i (code_sel),
    .legal_o(code_legal),
    .last_o (last_bit)
  );

  dline_cnt #(.W(CNT_W)) u_dcnt (
    .clk(clk), .rst_n(rst_n), .clr(d_clr), .inc(d_inc), .cnt_o(dcnt)
  );

  dline_cnt #(.W(CRC_CW)) u_ccnt (
    .clk(clk), .rst_n(rst_n), .clr(c_clr), .inc(c_inc), .cnt_o(ccnt)
  );

  dline_crc16 #(.POLY(POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(crc_din), .crc_o(crc)
  );

  assign bidx        = dcnt[2:0];
  assign stream_stop = (bidx == 3'd0) && !c_blk && !cfg_en_i;
  assign rx_stall    = (bidx == 3'd7) && rx_valid_q && !rx_ready_i;

  always_comb begin
    st_n       = st;
    bit_slot_o = 1'b0;
    line_o     = 1'b1;
    tx_ready_o = 1'b0;
    d_clr      = 1'b0;
    d_inc      = 1'b0;
    c_clr      = 1'b0;
    c_inc      = 1'b0;
    crc_clr    = 1'b0;
    crc_en     = 1'b0;
    crc_din    = 1'b0;
    start      = 1'b0;
    lerr_set   = 1'b0;
    blk_end    = 1'b0;
    tx_adv     = 1'b0;
    rx_adv     = 1'b0;

    case (st)
      S_IDLE: begin
        if (cfg_en_i) begin
          if (cfg_blk_i && !code_legal) begin
            lerr_set = 1'b1;
            st_n     = S_HOLD;
          end else begin
            start   = 1'b1;
            d_clr   = 1'b1;
            c_clr   = 1'b1;
            crc_clr = 1'b1;
            st_n    = cfg_tx_i ? S_TSTART : S_RWAIT;
          end
        end
      end
      S_HOLD: begin
        if (!cfg_en_i) st_n = S_IDLE;
      end
      S_TSTART: begin
        bit_slot_o = 1'b1;
        line_o     = 1'b0;
        st_n       = S_TDATA;
      end
      S_TDATA: begin
        if (stream_stop) begin
          st_n = S_TEND;
        end else if (bidx == 3'd0) begin
          tx_ready_o = 1'b1;
          if (tx_valid_i) begin
            tx_adv = 1'b1;
            line_o = tx_data_i[7];
          end
        end else begin
          tx_adv = 1'b1;
          line_o = sh[7];
        end
        if (tx_adv) begin
          bit_slot_o = 1'b1;
          d_inc      = 1'b1;
          crc_en     = 1'b1;
          crc_din    = line_o;
          if (c_blk && dcnt == last_bit) st_n = S_TCRC;
        end
      end
      S_TCRC: begin
        // Feeding the register its own top bit shifts it out unchanged.
        bit_slot_o = 1'b1;
        line_o     = crc[15];
        crc_en     = 1'b1;
        crc_din    = crc[15];
        c_inc      = 1'b1;
        if (ccnt == CRC_CW'(15)) st_n = S_TEND;
      end
      S_TEND: begin
        bit_slot_o = 1'b1;
        line_o     = 1'b1;
        blk_end    = 1'b1;
      end
      S_RWAIT: begin
        if (!cfg_en_i) begin
          st_n = S_HOLD;
        end else begin
          bit_slot_o = 1'b1;
          if (!line_i) st_n = S_RDATA;
        end
      end
      S_RDATA: begin
        if (stream_stop) begin
          st_n = S_REND;
        end else if (!rx_stall) begin
          rx_adv     = 1'b1;
          bit_slot_o = 1'b1;
          d_inc      = 1'b1;
          crc_en     = 1'b1;
          crc_din    = line_i;
          if (c_blk && dcnt == last_bit) st_n = S_RCRC;
        end
      end
      S_RCRC: begin
        // The received CRC runs through the same register; a match leaves zero.
        bit_slot_o = 1'b1;
        crc_en     = 1'b1;
        crc_din    = line_i;
        c_inc      = 1'b1;
        if (ccnt == CRC_CW'(15)) st_n = S_REND;
      end
      S_REND: begin
        bit_slot_o = 1'b1;
        blk_end    = 1'b1;
      end
      default: st_n = S_IDLE;
    endcase

    if (blk_end) begin
      if (c_blk && c_multi && cfg_en_i) begin
        d_clr   = 1'b1;
        c_clr   = 1'b1;
        crc_clr = 1'b1;
        st_n    = c_tx ? S_TSTART : S_RWAIT;
      end else begin
        st_n = S_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      c_tx       <= 1'b0;
      c_blk      <= 1'b0;
      c_multi    <= 1'b0;
      c_code     <= '0;
      sh         <= '0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      eof_q      <= 1'b0;
      lerr_q     <= 1'b0;
      crc_err_q  <= 1'b0;
      fmt_err_q  <= 1'b0;
    end else begin
      st    <= st_n;
      eof_q <= blk_end;

      if (start) begin
        c_tx      <= cfg_tx_i;
        c_blk     <= cfg_blk_i;
        c_multi   <= cfg_multi_i;
        c_code    <= cfg_len_i;
        crc_err_q <= 1'b0;
        fmt_err_q <= 1'b0;
      end

      if (lerr_set)                      lerr_q <= 1'b1;
      else if (st == S_HOLD && !cfg_en_i) lerr_q <= 1'b0;

      if (tx_adv) sh <= (bidx == 3'd0) ? {tx_data_i[6:0], 1'b0} : {sh[6:0], 1'b0};
      if (rx_adv) sh <= {sh[6:0], line_i};

      if (rx_adv && bidx == 3'd7) begin
        rx_data_q  <= {sh[6:0], line_i};
        rx_valid_q <= 1'b1;
      end else if (rx_ready_i) begin
        rx_valid_q <= 1'b0;
      end

      if (blk_end && !c_tx) begin
        fmt_err_q <= !line_i;
        crc_err_q <= c_blk && (crc != 16'h0000);
      end
    end
  end

  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign busy_o     = (st != S_IDLE) && (st != S_HOLD);
  assign eof_o      = eof_q;
  assign len_err_o  = lerr_q;
  assign crc_err_o  = crc_err_q;
  assign fmt_err_o  = fmt_err_q;

endmodule

// File: rtl/dline_seq_chk.sv
module dline_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_o,
  input logic       bit_slot_o,
  input logic       busy_o,
  input logic       eof_o,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic [7:0] tx_data_i,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic [7:0] rx_data_o,
  input logic       len_err_o,
  input logic       crc_err_o,
  input logic       fmt_err_o
);

  // R3
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> line_o);

  // R5
  tx_msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |-> (bit_slot_o && line_o == tx_data_i[7]));

  // R5
  tx_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> busy_o);

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R2
  len_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_o |-> (!busy_o && !bit_slot_o));

  // R12
  eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |=> !eof_o);

  // R7
  fmt_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_err_o) |-> (eof_o || $rose(busy_o)));

  // R7
  crc_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(crc_err_o) |-> (eof_o || $rose(busy_o)));

  // R11
  slot_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_slot_o |-> busy_o);

endmodule

bind dline_seq dline_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_o    (line_o),
  .bit_slot_o(bit_slot_o),
  .busy_o    (busy_o),
  .eof_o     (eof_o),
  .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o),
  .tx_data_i (tx_data_i),
  .rx_valid_o(rx_valid_o),
  .rx_ready_i(rx_ready_i),
  .rx_data_o (rx_data_o),
  .len_err_o (len_err_o),
  .crc_err_o (crc_err_o),
  .fmt_err_o (fmt_err_o)
);

// File: tb/dline_seq_tb.sv
`timescale 1ns/1ps
module dline_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en_i = 1'b0, cfg_tx_i = 1'b0, cfg_blk_i = 1'b0, cfg_multi_i = 1'b0;
  logic [3:0] cfg_len_i = '0;
  logic [7:0] tx_data_i = '0;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic       rx_ready_i = 1'b1;
  logic       line_o;
  logic       line_i = 1'b1;
  logic       bit_slot_o, busy_o, eof_o, len_err_o, crc_err_o, fmt_err_o;

  always #2 clk = ~clk;

  dline_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_en_i(cfg_en_i), .cfg_tx_i(cfg_tx_i), .cfg_blk_i(cfg_blk_i),
    .cfg_multi_i(cfg_multi_i), .cfg_len_i(cfg_len_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .line_o(line_o), .line_i(line_i), .bit_slot_o(bit_slot_o),
    .busy_o(busy_o), .eof_o(eof_o), .len_err_o(len_err_o),
    .crc_err_o(crc_err_o), .fmt_err_o(fmt_err_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int slot_idle_err = 0;
  logic stall_on = 1'b0;
  logic [15:0] rnd = 16'hACE1;

  logic [7:0] txq[$];
  logic [7:0] exp_b[$];
  logic [7:0] rxcap[$];
  logic       exp_q[$];
  logic       cap_q[$];
  logic       rxf[$];
  logic       eof_crc[$];
  logic       eof_fmt[$];

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 13 + (i >> 3) + 5) & 255);
  endfunction

  // Card side and stream endpoints, all driven and sampled mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      rx_ready_i = stall_on ? rnd[0] : 1'b1;
      tx_valid_i = (txq.size() > 0) && (stall_on ? (rnd[1] | rnd[2]) : 1'b1);
      tx_data_i  = (txq.size() > 0) ? txq[0] : 8'h00;
      line_i     = (rxf.size() > 0) ? rxf[0] : 1'b1;
      rnd = {rnd[14:0], rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10]};
      #1;
      if (bit_slot_o) begin
        cap_q.push_back(line_o);
        if (rxf.size() > 0) void'(rxf.pop_front());
        if (!busy_o) slot_idle_err++;
      end
      if (tx_valid_i && tx_ready_o) void'(txq.pop_front());
      if (rx_valid_o && rx_ready_i) rxcap.push_back(rx_data_o);
      if (eof_o) begin
        eof_crc.push_back(crc_err_o);
        eof_fmt.push_back(fmt_err_o);
      end
    end
  end

  task automatic clear_all();
    txq.delete(); exp_b.delete(); rxcap.delete(); exp_q.delete();
    cap_q.delete(); rxf.delete(); eof_crc.delete(); eof_fmt.delete();
  endtask

  task automatic set_cfg(input logic en, input logic tx, input logic blk,
                         input logic multi, input logic [3:0] len);
    @(posedge clk); #1;
    cfg_tx_i = tx; cfg_blk_i = blk; cfg_multi_i = multi; cfg_len_i = len; cfg_en_i = en;
  endtask

  task automatic drop_en();
    @(posedge clk); #1;
    cfg_en_i = 1'b0;
  endtask

  task automatic wait_eof(input int n, input string req);
    int t = 0;
    while (eof_crc.size() < n && t < 40000) begin
      @(posedge clk);
      t++;
    end
    check(eof_crc.size() >= n, req, eof_crc.size(), n);
  endtask

  task automatic add_tx_block(input int nbytes, input int seed);
    logic [15:0] c = 16'h0000;
    exp_q.push_back(1'b0);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b = pat(seed, i);
      txq.push_back(b);
      for (int k = 7; k >= 0; k--) begin
        exp_q.push_back(b[k]);
        c = crc_upd(c, b[k]);
      end
    end
    for (int k = 15; k >= 0; k--) exp_q.push_back(c[k]);
    exp_q.push_back(1'b1);
  endtask

  task automatic add_rx_block(input int nbytes, input int seed,
                              input logic bad_crc, input logic bad_end);
    logic [15:0] c = 16'h0000;
    rxf.push_back(1'b0);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b = pat(seed, i);
      exp_b.push_back(b);
      for (int k = 7; k >= 0; k--) begin
        rxf.push_back(b[k]);
        c = crc_upd(c, b[k]);
      end
    end
    if (bad_crc) c = c ^ 16'h0100;
    for (int k = 15; k >= 0; k--) rxf.push_back(c[k]);
    rxf.push_back(!bad_end);
  endtask

  task automatic cmp_bits(input string req);
    int bad = -1;
    check(cap_q.size() == exp_q.size(), req, cap_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
      if (bad < 0 && cap_q[i] !== exp_q[i]) bad = i;
    check(bad < 0, req, bad, -1);
  endtask

  task automatic cmp_bytes(input string req);
    int bad = -1;
    check(rxcap.size() == exp_b.size(), req, rxcap.size(), exp_b.size());
    for (int i = 0; i < exp_b.size() && i < rxcap.size(); i++)
      if (bad < 0 && rxcap[i] !== exp_b[i]) bad = i;
    check(bad < 0, req, bad, -1);
  endtask

  task automatic run_tx_single(input int code);
    clear_all();
    add_tx_block(1 << code, code + 1);
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 4'(code));
    wait_eof(1, "R12 tx single eof");
    repeat (6) @(posedge clk);
    #1;
    check(eof_crc.size() == 1, "R12 one eof per tx block", eof_crc.size(), 1);
    cmp_bits("R3/R4/R1 tx frame");
    check(txq.size() == 0, "R5 all tx bytes taken", txq.size(), 0);
    check(busy_o == 1'b0, "R8 busy low after single block", busy_o, 0);
    drop_en();
    repeat (3) @(posedge clk);
  endtask

  task automatic run_rx_single(input int code, input logic bad_crc, input logic bad_end);
    clear_all();
    repeat (3) rxf.push_back(1'b1);
    add_rx_block(1 << code, code + 40, bad_crc, bad_end);
    repeat (4) rxf.push_back(1'b1);
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 4'(code));
    wait_eof(1, "R12 rx single eof");
    repeat (6) @(posedge clk);
    #1;
    cmp_bytes("R6 rx bytes");
    if (eof_crc.size() > 0) begin
      check(eof_crc[0] == bad_crc, "R7 crc status", eof_crc[0], bad_crc);
      check(eof_fmt[0] == bad_end, "R7 format status", eof_fmt[0], bad_end);
    end
    check(busy_o == 1'b0, "R8 rx idle after single block", busy_o, 0);
    drop_en();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(busy_o == 1'b0, "R11 busy after reset", busy_o, 0);
    check(line_o == 1'b1, "R3 idle line high", line_o, 1);
    check(eof_o == 1'b0 && len_err_o == 1'b0, "R12 no eof after reset", eof_o, 0);
    check(rx_valid_o == 1'b0 && tx_ready_o == 1'b0, "R6 no handshake after reset", rx_valid_o, 0);

    // Block transmit sweep with stalls, then the longest block without.
    stall_on = 1'b1;
    for (int code = 0; code <= 5; code++) run_tx_single(code);
    stall_on = 1'b0;
    run_tx_single(11);

    // Block receive sweep: corrupted CRC, bad end bit, then clean frames.
    stall_on = 1'b1;
    for (int code = 0; code <= 4; code++)
      run_rx_single(code, code == 2, code == 3);
    stall_on = 1'b0;

    // R9 multi-block transmit: enable dropped during the second block.
    clear_all();
    add_tx_block(2, 7);
    add_tx_block(2, 9);
    set_cfg(1'b1, 1'b1, 1'b1, 1'b1, 4'd1);
    wait_eof(1, "R9 first tx block");
    drop_en();
    wait_eof(2, "R9 second tx block");
    repeat (40) @(posedge clk);
    #1;
    check(eof_crc.size() == 2, "R9 tx block count", eof_crc.size(), 2);
    cmp_bits("R9 multi tx frames");
    repeat (3) @(posedge clk);

    // R9 multi-block receive, second block carries a bad CRC.
    clear_all();
    rxf.push_back(1'b1);
    add_rx_block(2, 11, 1'b0, 1'b0);
    add_rx_block(2, 13, 1'b1, 1'b0);
    repeat (4) rxf.push_back(1'b1);
    set_cfg(1'b1, 1'b0, 1'b1, 1'b1, 4'd1);
    wait_eof(1, "R9 first rx block");
    drop_en();
    wait_eof(2, "R9 second rx block");
    repeat (40) @(posedge clk);
    #1;
    check(eof_crc.size() == 2, "R9 rx block count", eof_crc.size(), 2);
    cmp_bytes("R9 multi rx bytes");
    if (eof_crc.size() == 2) begin
      check(eof_crc[0] == 1'b0, "R7 first block crc clean", eof_crc[0], 0);
      check(eof_crc[1] == 1'b1, "R7 second block crc error", eof_crc[1], 1);
    end
    repeat (3) @(posedge clk);

    // R10 stream transmit with a reserved length code, which must be ignored.
    clear_all();
    for (int i = 0; i < 3; i++) txq.push_back(pat(21, i));
    exp_q.push_back(1'b0);
    for (int i = 0; i < 3; i++)
      for (int k = 7; k >= 0; k--) exp_q.push_back(pat(21, i) >> k);
    exp_q.push_back(1'b1);
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 4'd15);
    while (txq.size() > 0) @(posedge clk);
    #1 cfg_en_i = 1'b0;
    wait_eof(1, "R10 stream tx eof");
    repeat (6) @(posedge clk);
    #1;
    check(len_err_o == 1'b0, "R10 stream ignores length code", len_err_o, 0);
    cmp_bits("R10 stream tx frame");

    // R10 stream receive of two bytes.
    clear_all();
    repeat (2) rxf.push_back(1'b1);
    rxf.push_back(1'b0);
    for (int i = 0; i < 2; i++) begin
      exp_b.push_back(pat(33, i));
      for (int k = 7; k >= 0; k--) rxf.push_back(pat(33, i) >> k);
    end
    rxf.push_back(1'b1);
    repeat (4) rxf.push_back(1'b1);
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    while (rxcap.size() < 1) @(posedge clk);
    drop_en();
    wait_eof(1, "R10 stream rx eof");
    repeat (6) @(posedge clk);
    #1;
    cmp_bytes("R10 stream rx bytes");
    if (eof_crc.size() > 0) begin
      check(eof_crc[0] == 1'b0, "R7 stream has no crc error", eof_crc[0], 0);
      check(eof_fmt[0] == 1'b0, "R7 stream end bit good", eof_fmt[0], 0);
    end

    // R2 reserved length codes in block format.
    for (int code = 12; code <= 15; code += 3) begin
      clear_all();
      set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 4'(code));
      repeat (5) @(posedge clk);
      #1;
      check(len_err_o == 1'b1, "R2 reserved code flagged", len_err_o, 1);
      check(busy_o == 1'b0, "R2 reserved code not busy", busy_o, 0);
      check(cap_q.size() == 0, "R2 no bits moved", cap_q.size(), 0);
      drop_en();
      repeat (2) @(posedge clk);
      #1;
      check(len_err_o == 1'b0, "R2 flag cleared by enable low", len_err_o, 0);
    end

    check(slot_idle_err == 0, "R11 slots only while busy", slot_idle_err, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule